// File: doc/BRIEF.md
# Fused Multiply-Add Special-Operand Resolver

This block sits at the front of a single-precision fused multiply-add unit. It receives the three operands (the addend z and the multiplicands x and y), each already tagged with an operand class. It also receives a two-bit variant selector, a fused-form flag and the current rounding mode. In the same cycle it decides whether the outcome of `z ± (x × y)` is already fixed by special operands. That covers NaN inputs, infinities, zero products and invalid combinations. When the outcome is fixed, the block drives the final 32-bit result and the invalid-operation flag.

When none of those rules applies, the block raises `compute`. The downstream mantissa datapath then performs the multiply, align, add and round. The block is purely combinational and has no state.

Class encoding on the `cls_*` inputs: 0 = zero, 1 = normal, 2 = subnormal, 3 = infinity, 4 = quiet NaN, 5 = signalling NaN. Rounding-mode encoding on `rmode`: 0 = nearest even, 1 = toward zero, 2 = toward +inf, 3 = toward -inf.

Top module: `fma_special_resolver`

## Requirements
- R1: If any operand is a signalling NaN, the first one in the order z, x, y is returned with fraction bit 22 forced to 1. Its sign and other payload bits are kept, and `invalid` is 1.
- R2: With no signalling NaN present, the first quiet NaN in the order z, x, y is returned bit-for-bit, and `invalid` is 0. Any signalling NaN anywhere outranks every quiet NaN.
- R3: With no NaN present, infinity times zero (either order) returns 0x7FC00000 with `invalid` = 1, whatever z is.
- R4: With no NaN present, a product with an infinite factor (other factor normal, subnormal or infinite) and an infinite z of a different effective sign returns 0x7FC00000 with `invalid` = 1.
- R5: Otherwise a product with an infinite factor returns infinity carrying the effective product sign, with `invalid` = 0.
- R6: A zero product (neither factor infinite) with an infinite z returns infinity carrying the effective addend sign.
- R7: A zero product with a zero z returns z bit-for-bit when the effective signs match. When they differ it returns +0, or -0 when `rmode` = 3.
- R8: A zero product with a finite non-zero z (normal or subnormal) returns z bit-for-bit.
- R9: When x and y are both finite and non-zero and z is infinite, the result is infinity carrying the effective addend sign.
- R10: `compute` is 1 exactly when none of R1 to R9 applies. In that case `result` is 0 and `invalid` is 0.
- R11: Effective product sign = sign(x) XOR sign(y) XOR negate-product, and effective addend sign = sign(z) XOR negate-addend. The negation flags depend on `variant` and `fused_form`:
  - `variant` 0: no negation.
  - `variant` 1: negate-addend, or negate-product instead when `fused_form` = 1.
  - `variant` 2: both flags set.
  - `variant` 3: negate-product only.
- R12: `invalid` = 1 only together with a NaN result whose quiet bit (bit 22) is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_z | input | 32 | Addend operand bits |
| op_x | input | 32 | First multiplicand bits |
| op_y | input | 32 | Second multiplicand bits |
| cls_z | input | 3 | Class of op_z |
| cls_x | input | 3 | Class of op_x |
| cls_y | input | 3 | Class of op_y |
| variant | input | 2 | Operation variant selector |
| fused_form | input | 1 | Variant 1 negates the product instead of the addend |
| rmode | input | 2 | Rounding mode |
| result | output | 32 | Resolved result (0 when compute is high) |
| invalid | output | 1 | Invalid-operation flag |
| compute | output | 1 | No special case applied; datapath must compute |

## Verification
Two rules can fire on one operand set: NaN selection and the infinity-times-zero invalid rule. The same goes for NaN selection and the opposite-sign infinity rule. The NaN rule must win, which decides both the payload returned and whether `invalid` comes from a quieted signalling NaN or from the indefinite value. Directed cases combine a NaN z with an infinite x and a zero y, and random classes weighted toward specials produce many more such overlaps. Every case is judged against a bench model that applies the rules in the stated order.

// File: rtl/fma_sr_pkg.sv
// Package: shared operand-class encoding and variant codes for the
// FMA special-operand resolver. Assumes classes arrive pre-decoded.
package fma_sr_pkg;

    typedef enum logic [2:0] {
        CLS_ZERO = 3'd0,
        CLS_NORM = 3'd1,
        CLS_SUB  = 3'd2,
        CLS_INF  = 3'd3,
        CLS_QNAN = 3'd4,
        CLS_SNAN = 3'd5
    } op_class_e;

    localparam logic [1:0] VAR_MADD  = 2'd0;
    localparam logic [1:0] VAR_MSUB  = 2'd1;
    localparam logic [1:0] VAR_NMADD = 2'd2;
    localparam logic [1:0] VAR_NMSUB = 2'd3;

    localparam logic [1:0] RM_DOWN = 2'd3;

endpackage

// File: rtl/fma_sign_prep.sv
// Module: derives the effective product and addend signs from the raw
// operand signs, the variant code and the fused-form flag.
// Assumes: variant codes as in fma_sr_pkg.
module fma_sign_prep
    import fma_sr_pkg::*;
(
    input  logic       sign_x,
    input  logic       sign_y,
    input  logic       sign_z,
    input  logic [1:0] variant,
    input  logic       fused_form,
    output logic       prod_sign,
    output logic       add_sign
);

    logic neg_prod;
    logic neg_add;

    // Decode the variant into the two negation flags.
    always_comb begin
        unique case (variant)
            VAR_MADD:  begin neg_prod = 1'b0;       neg_add = 1'b0;        end
            VAR_MSUB:  begin neg_prod = fused_form; neg_add = !fused_form; end
            VAR_NMADD: begin neg_prod = 1'b1;       neg_add = 1'b1;        end
            default:   begin neg_prod = 1'b1;       neg_add = 1'b0;        end
        endcase
    end

    // Apply the negations to the raw signs.
    always_comb begin
        prod_sign = sign_x ^ sign_y ^ neg_prod;
        add_sign  = sign_z ^ neg_add;
    end

endmodule

// File: rtl/fma_nan_pick.sv
// Module: selects the NaN result when any operand is a NaN.
// Any signalling NaN outranks any quiet NaN; within a kind the lowest
// index wins (index 0 = z, 1 = x, 2 = y). Signalling NaNs are quieted.
// Assumes: classes are consistent with the operand bits.
module fma_nan_pick
    import fma_sr_pkg::*;
#(
    parameter int W      = 32,
    parameter int N_OPS  = 3,
    parameter int QBIT   = 22
) (
    input  logic [N_OPS-1:0][W-1:0] ops,
    input  logic [N_OPS-1:0][2:0]   cls,
    output logic                    hit,
    output logic                    raise_inv,
    output logic [W-1:0]            value
);

    logic [N_OPS-1:0] is_snan;
    logic [N_OPS-1:0] is_qnan;
    logic [W-1:0]     snan_sel;
    logic [W-1:0]     qnan_sel;

    // Per-operand NaN kind detection.
    for (genvar i = 0; i < N_OPS; i++) begin : g_kind
        assign is_snan[i] = (cls[i] == CLS_SNAN);
        assign is_qnan[i] = (cls[i] == CLS_QNAN);
    end

    // Priority pick: scan from the highest index so the lowest one wins.
    always_comb begin
        snan_sel = '0;
        qnan_sel = '0;
        for (int i = N_OPS - 1; i >= 0; i--) begin
            if (is_snan[i]) snan_sel = ops[i];
            if (is_qnan[i]) qnan_sel = ops[i];
        end
    end

    // Merge the two kinds; signalling first, quieted on the way out.
    always_comb begin
        hit       = |is_snan || |is_qnan;
        raise_inv = |is_snan;
        if (|is_snan) begin
            value       = snan_sel;
            value[QBIT] = 1'b1;
        end else if (|is_qnan) begin
            value = qnan_sel;
        end else begin
            value = '0;
        end
    end

endmodule

// File: rtl/fma_inf_zero_rules.sv
// Module: infinity and zero rules for non-NaN operands. Produces a
// fixed result for inf*0, inf-inf, infinite products, zero products
// and finite products meeting an infinite addend.
// Assumes: no operand is a NaN (the NaN path outranks this one).
module fma_inf_zero_rules
    import fma_sr_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] op_z,
    input  logic [2:0]            cls_x,
    input  logic [2:0]            cls_y,
    input  logic [2:0]            cls_z,
    input  logic                  prod_sign,
    input  logic                  add_sign,
    input  logic [1:0]            rmode,
    output logic                  hit,
    output logic                  raise_inv,
    output logic [EXP_W+FRAC_W:0] value
);

    localparam int W = EXP_W + FRAC_W + 1;
    localparam logic [W-1:0] DEF_NAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    logic x_inf, y_inf, x_zero, y_zero, z_inf, z_zero;

    // Class shorthand for the rule tree.
    always_comb begin
        x_inf  = (cls_x == CLS_INF);
        y_inf  = (cls_y == CLS_INF);
        x_zero = (cls_x == CLS_ZERO);
        y_zero = (cls_y == CLS_ZERO);
        z_inf  = (cls_z == CLS_INF);
        z_zero = (cls_z == CLS_ZERO);
    end

    // Rule tree, in decreasing priority.
    always_comb begin
        hit       = 1'b1;
        raise_inv = 1'b0;
        value     = '0;
        if ((x_inf && y_zero) || (x_zero && y_inf)) begin
            raise_inv = 1'b1;
            value     = DEF_NAN;
        end else if (x_inf || y_inf) begin
            if (z_inf && (add_sign != prod_sign)) begin
                raise_inv = 1'b1;
                value     = DEF_NAN;
            end else begin
                value = {prod_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            end
        end else if (x_zero || y_zero) begin
            if (z_inf) begin
                value = {add_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            end else if (z_zero && (add_sign != prod_sign)) begin
                value = {(rmode == RM_DOWN), {(W-1){1'b0}}};
            end else begin
                value = op_z;
            end
        end else if (z_inf) begin
            value = {add_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        end else begin
            hit = 1'b0;
        end
    end

endmodule

// File: rtl/fma_special_resolver.sv
// Module: top of the FMA special-operand resolver. Combines sign
// preparation, NaN selection and the infinity/zero rules; raises
// compute when no rule fixes the result. Purely combinational.
// Assumes: cls_* agree with the operand bits.
module fma_special_resolver
    import fma_sr_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] op_z,
    input  logic [EXP_W+FRAC_W:0] op_x,
    input  logic [EXP_W+FRAC_W:0] op_y,
    input  logic [2:0]            cls_z,
    input  logic [2:0]            cls_x,
    input  logic [2:0]            cls_y,
    input  logic [1:0]            variant,
    input  logic                  fused_form,
    input  logic [1:0]            rmode,
    output logic [EXP_W+FRAC_W:0] result,
    output logic                  invalid,
    output logic                  compute
);

    localparam int W    = EXP_W + FRAC_W + 1;
    localparam int QBIT = FRAC_W - 1;

    logic prod_sign, add_sign;
    logic nan_hit, nan_inv;
    logic [W-1:0] nan_val;
    logic iz_hit, iz_inv;
    logic [W-1:0] iz_val;
    logic [2:0][W-1:0] ops_vec;
    logic [2:0][2:0]   cls_vec;

    // Priority-ordered operand vectors: z, x, y.
    assign ops_vec = {op_y, op_x, op_z};
    assign cls_vec = {cls_y, cls_x, cls_z};

    fma_sign_prep u_sign (
        .sign_x     (op_x[W-1]),
        .sign_y     (op_y[W-1]),
        .sign_z     (op_z[W-1]),
        .variant    (variant),
        .fused_form (fused_form),
        .prod_sign  (prod_sign),
        .add_sign   (add_sign)
    );

    fma_nan_pick #(.W(W), .N_OPS(3), .QBIT(QBIT)) u_nan (
        .ops       (ops_vec),
        .cls       (cls_vec),
        .hit       (nan_hit),
        .raise_inv (nan_inv),
        .value     (nan_val)
    );

    fma_inf_zero_rules #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_iz (
        .op_z      (op_z),
        .cls_x     (cls_x),
        .cls_y     (cls_y),
        .cls_z     (cls_z),
        .prod_sign (prod_sign),
        .add_sign  (add_sign),
        .rmode     (rmode),
        .hit       (iz_hit),
        .raise_inv (iz_inv),
        .value     (iz_val)
    );

    // Final merge: NaN path outranks the infinity/zero path.
    always_comb begin
        if (nan_hit) begin
            result  = nan_val;
            invalid = nan_inv;
            compute = 1'b0;
        end else if (iz_hit) begin
            result  = iz_val;
            invalid = iz_inv;
            compute = 1'b0;
        end else begin
            result  = '0;
            invalid = 1'b0;
            compute = 1'b1;
        end
    end

endmodule

// File: rtl/fma_special_resolver_chk.sv
// Checker: immediate assertions over the resolver's ports, bound to
// every instance of the top module.
module fma_special_resolver_chk
    import fma_sr_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input logic [EXP_W+FRAC_W:0] op_z,
    input logic [EXP_W+FRAC_W:0] op_x,
    input logic [EXP_W+FRAC_W:0] op_y,
    input logic [2:0]            cls_z,
    input logic [2:0]            cls_x,
    input logic [2:0]            cls_y,
    input logic [1:0]            variant,
    input logic                  fused_form,
    input logic [1:0]            rmode,
    input logic [EXP_W+FRAC_W:0] result,
    input logic                  invalid,
    input logic                  compute
);

    localparam int W = EXP_W + FRAC_W + 1;
    localparam logic [W-1:0] DEF_NAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    logic any_snan, any_qnan, inf_times_zero;

    // Port-level predicates for the checks below.
    always_comb begin
        any_snan = (cls_z == CLS_SNAN) || (cls_x == CLS_SNAN) || (cls_y == CLS_SNAN);
        any_qnan = (cls_z == CLS_QNAN) || (cls_x == CLS_QNAN) || (cls_y == CLS_QNAN);
        inf_times_zero = ((cls_x == CLS_INF) && (cls_y == CLS_ZERO)) ||
                         ((cls_x == CLS_ZERO) && (cls_y == CLS_INF));
    end

    // Check the resolved outputs against the rules.
    always_comb begin
        // R1
        snan_raises_invalid_chk: assert (!any_snan || invalid);
        // R2
        qnan_quiet_chk: assert (any_snan || !any_qnan || (!invalid && !compute));
        // R3
        inf_zero_default_chk: assert (any_snan || any_qnan || !inf_times_zero ||
                                      (invalid && result == DEF_NAN));
        // R10
        compute_clean_chk: assert (!compute || (result == '0 && !invalid));
        // R12
        invalid_is_nan_chk: assert (!invalid || (&result[W-2:FRAC_W] && result[FRAC_W-1]));
    end

endmodule

bind fma_special_resolver fma_special_resolver_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (.*);

// File: tb/tb_fma_special_resolver.sv
// Bench: directed corner cases plus seeded random operands, checked
// against a rule model written from the requirements.
module tb_fma_special_resolver;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [31:0] op_z, op_x, op_y, result;
    logic [2:0]  cls_z, cls_x, cls_y;
    logic [1:0]  variant, rmode;
    logic        fused_form, invalid, compute;
    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    localparam logic [31:0] DNAN = 32'h7FC0_0000;

    always #4 clk = ~clk;

    fma_special_resolver dut (.*);

    // Class of a bit pattern: 0 zero,1 norm,2 sub,3 inf,4 qnan,5 snan.
    function automatic logic [2:0] cls_of(input logic [31:0] v);
        if (v[30:23] == 8'hFF) begin
            if (v[22:0] == 0) return 3'd3;
            return v[22] ? 3'd4 : 3'd5;
        end
        if (v[30:23] == 0) return (v[22:0] == 0) ? 3'd0 : 3'd2;
        return 3'd1;
    endfunction

    // Build a random operand of the given class.
    function automatic logic [31:0] make_op(input logic [2:0] c);
        logic s;
        logic [22:0] f;
        logic [7:0] e;
        s = 1'($urandom);
        f = 23'($urandom);
        e = 8'($urandom_range(1, 254));
        case (c)
            3'd0:    return {s, 31'd0};
            3'd1:    return {s, e, f};
            3'd2:    return {s, 8'd0, (f == 0) ? 23'd1 : f};
            3'd3:    return {s, 8'hFF, 23'd0};
            3'd4:    return {s, 8'hFF, 1'b1, f[21:0]};
            default: return {s, 8'hFF, 1'b0, (f[21:0] == 0) ? 22'd5 : f[21:0]};
        endcase
    endfunction

    // Rule model: returns {compute, invalid, result} and the rule tag.
    function automatic logic [33:0] model(input logic [31:0] z, x, y,
                                          input logic [1:0] v, input logic ff,
                                          input logic [1:0] rm, output string tag);
        logic [2:0] cz, cx, cy;
        logic np, na, ps, as;
        cz = cls_of(z); cx = cls_of(x); cy = cls_of(y);
        // R11 sign preparation
        np = (v == 2'd2) || (v == 2'd3) || (v == 2'd1 && ff);
        na = (v == 2'd2) || (v == 2'd1 && !ff);
        ps = x[31] ^ y[31] ^ np;
        as = z[31] ^ na;
        tag = "R1";
        if (cz == 5) return {2'b01, z | 32'h0040_0000};
        if (cx == 5) return {2'b01, x | 32'h0040_0000};
        if (cy == 5) return {2'b01, y | 32'h0040_0000};
        tag = "R2";
        if (cz == 4) return {2'b00, z};
        if (cx == 4) return {2'b00, x};
        if (cy == 4) return {2'b00, y};
        tag = "R3";
        if ((cx == 3 && cy == 0) || (cx == 0 && cy == 3)) return {2'b01, DNAN};
        if (cx == 3 || cy == 3) begin
            tag = "R4";
            if (cz == 3 && as != ps) return {2'b01, DNAN};
            tag = "R5";
            return {2'b00, ps, 8'hFF, 23'd0};
        end
        if (cx == 0 || cy == 0) begin
            tag = "R6";
            if (cz == 3) return {2'b00, as, 8'hFF, 23'd0};
            tag = "R7";
            if (cz == 0) return (as == ps) ? {2'b00, z} : {2'b00, rm == 2'd3, 31'd0};
            tag = "R8";
            return {2'b00, z};
        end
        tag = "R9";
        if (cz == 3) return {2'b00, as, 8'hFF, 23'd0};
        tag = "R10";
        return {2'b10, 32'd0};
    endfunction

    // Drive one case, wait, compare all outputs with the model.
    task automatic run(input logic [31:0] z, x, y, input logic [1:0] v,
                       input logic ff, input logic [1:0] rm, input string note);
        logic [33:0] exp_v;
        string tag;
        @(negedge clk);
        op_z = z; op_x = x; op_y = y;
        cls_z = cls_of(z); cls_x = cls_of(x); cls_y = cls_of(y);
        variant = v; fused_form = ff; rmode = rm;
        #2;
        exp_v = model(z, x, y, v, ff, rm, tag);
        n_checks++;
        if ({compute, invalid, result} !== exp_v) begin
            n_fail++;
            $display("FAIL %s %s: got c=%0b i=%0b r=%h exp c=%0b i=%0b r=%h",
                     tag, note, compute, invalid, result, exp_v[33], exp_v[32], exp_v[31:0]);
        end
    endtask

    initial begin
        op_z = 0; op_x = 0; op_y = 0; cls_z = 0; cls_x = 0; cls_y = 0;
        variant = 0; fused_form = 0; rmode = 0;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R10 plain finite operands go to the datapath
        run(32'h3F80_0000, 32'h4000_0000, 32'h4040_0000, 2'd0, 1'b0, 2'd0, "R10 normals");
        // R1 sNaN order: z beats x; x beats y; sNaN y beats qNaN z
        run(32'hFF80_0011, 32'h7F80_0022, 32'h3F80_0000, 2'd0, 1'b0, 2'd0, "R1 z first");
        run(32'h3F80_0000, 32'h7F80_0022, 32'h7F80_0033, 2'd0, 1'b0, 2'd0, "R1 x before y");
        run(32'h7FC0_0044, 32'h3F80_0000, 32'hFF80_0033, 2'd0, 1'b0, 2'd0, "R1 snan beats qnan");
        // R2 qNaN passthrough, x before y
        run(32'h0000_0000, 32'hFFC1_2345, 32'h7FC0_0001, 2'd0, 1'b0, 2'd0, "R2 qnan x");
        // R2 NaN z overlapping inf*0
        run(32'h7FE0_0000, 32'h7F80_0000, 32'h0000_0000, 2'd0, 1'b0, 2'd0, "R2 over inf*0");
        // R3 inf*0 both orders
        run(32'h3F80_0000, 32'h0000_0000, 32'hFF80_0000, 2'd0, 1'b0, 2'd0, "R3 0*inf");
        run(32'h7F80_0000, 32'h7F80_0000, 32'h8000_0000, 2'd1, 1'b0, 2'd0, "R3 inf*0");
        // R4 +inf*+1 + (-inf)
        run(32'hFF80_0000, 32'h7F80_0000, 32'h3F80_0000, 2'd0, 1'b0, 2'd0, "R4 opposite");
        // R5 same via msub negating addend
        run(32'hFF80_0000, 32'h7F80_0000, 32'h3F80_0000, 2'd1, 1'b0, 2'd0, "R5 msub");
        // R11 fused msub negates product instead
        run(32'hFF80_0000, 32'h7F80_0000, 32'h3F80_0000, 2'd1, 1'b1, 2'd0, "R11 fused");
        // R6 zero product, infinite z, nmadd flips addend
        run(32'h7F80_0000, 32'h0000_0000, 32'h3F80_0000, 2'd2, 1'b0, 2'd0, "R6 nmadd");
        // R7 signed zeros
        run(32'h0000_0000, 32'h8000_0000, 32'h3F80_0000, 2'd0, 1'b0, 2'd0, "R7 rne");
        run(32'h0000_0000, 32'h8000_0000, 32'h3F80_0000, 2'd0, 1'b0, 2'd3, "R7 down");
        run(32'h8000_0000, 32'h8000_0000, 32'h3F80_0000, 2'd0, 1'b0, 2'd3, "R7 same");
        // R8 zero product with subnormal z
        run(32'h8000_0123, 32'h0000_0000, 32'h0000_0001, 2'd3, 1'b0, 2'd0, "R8 sub z");
        // R9 finite product, infinite z, nmsub
        run(32'hFF80_0000, 32'h0000_0001, 32'h4000_0000, 2'd3, 1'b0, 2'd0, "R9 nmsub");
        // R12 and all rules: random classes weighted toward specials
        for (int i = 0; i < 3000; i++) begin
            logic [2:0] cz, cx, cy;
            cz = ($urandom_range(0, 3) == 0) ? 3'd1 : 3'($urandom_range(0, 5));
            cx = ($urandom_range(0, 3) == 0) ? 3'd1 : 3'($urandom_range(0, 5));
            cy = ($urandom_range(0, 3) == 0) ? 3'd1 : 3'($urandom_range(0, 5));
            run(make_op(cz), make_op(cx), make_op(cy), 2'($urandom), 1'($urandom),
                2'($urandom), "random");
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(8 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule